// File: doc/BRIEF.md
# Power-of-Two Clock Divider with Gated Off State

This block derives an output clock from an input clock. A 4-bit code, normally held in a configuration register, picks the ratio. One code stops the clock. A contiguous group of codes selects division by 64, 32, 16, 8, 4 or 2. One code passes the input clock straight through. Every code with its top bit set is reserved and behaves like the stop code.

All divided ratios are taken from the bits of a single free-running 6-bit counter, and every bit is low at the moment the counter wraps. The block registers the select on the input clock. It applies a new setting only on a falling input edge that follows a counter wrap. At that point the old output, the new output and the input clock are all low. This lets the ratio change while the clock runs, with no glitch and no runt pulse.

The output is an AND-OR of the input clock and the counter taps. Each enable is held in a falling-edge register, and at most one enable is set at a time.

Top module: `clkdiv_pow2`

## Requirements
- R1: While the asynchronous active-low reset is asserted, the output clock stays low whatever the select input shows. Reset clears the registered select to the stop code 0.
- R2: Code 0 holds the output clock low.
- R3: Code c with 1 <= c <= 6 divides the input clock by 2^(7-c), so code 1 divides by 64 and code 6 divides by 2. Each high phase and each low phase lasts exactly 2^(6-c) input cycles.
- R4: Code 7 passes the input clock through undivided. The output is high while the input clock is high and low while it is low.
- R5: Codes 8 through 15, which have bit 3 set, are reserved. They hold the output clock low, exactly as code 0 does.
- R6: A new code takes effect on the first falling input edge at which the internal counter reads zero. A change from the stop code shows its first output high phase within 132 + 2^(7-c) input half-cycles of the select change, where code 7 counts as c = 7.
- R7: Across any change between codes 0 to 7, no complete high phase is shorter than the shorter half-period of the two ratios or longer than the longer one. No complete low phase is shorter than the shorter half-period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to divide |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| div_sel_i | input | 4 | Ratio code: 0 stop, 1 to 6 divide by 64 down to 2, 7 pass-through, 8 to 15 reserved (stop) |
| clk_o | output | 1 | Divided, passed-through or stopped output clock |

## Verification
Every one of the 16 codes is held steady in turn. The bench then measures the lengths of complete high and low phases at quarter-cycle sampling points. This separates a wrong tap (the phase length is off by a factor of two), a broken pass-through (phases are not one half-cycle each) and a reserved code that leaks a clock (a high sample appears).

Every ordered pair of distinct codes 0 to 7 is then switched while the clock runs. The bench checks that the phases around the switch stay between the two half-periods, which exposes a change applied mid-phase. It also checks that the new ratio appears in steady state afterwards. Starting from the stop code, the delay to the first high phase is bounded, which catches a change that waits for the wrong wrap or never lands.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Default geometry: 6 counter bits give ratios up to 64, 4 select bits.
  localparam int unsigned DEF_CNT_W = 6;
  localparam int unsigned DEF_SEL_W = 4;

  // Code that passes the input clock through: one above the last divide code.
  function automatic int unsigned pass_code(input int unsigned cnt_w);
    return cnt_w + 1;
  endfunction
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int unsigned CNT_W = clkdiv_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_sync_n,
  input  logic             cnt_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) cnt_q <= '0;
    else             cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // R3: after the all-ones state the counter must wrap to zero
  p_wrap_to_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (cnt_en_i && (cnt_q == '1)) |=> zero_o);
endmodule

// File: rtl/clkdiv_sel_apply.sv
module clkdiv_sel_apply #(
  parameter int unsigned CNT_W = clkdiv_pkg::DEF_CNT_W,
  parameter int unsigned SEL_W = clkdiv_pkg::DEF_SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_sync_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             wrap_i,
  output logic             pass_o,
  output logic [CNT_W-1:0] tap_o
);
  localparam int unsigned PASS_CODE = clkdiv_pkg::pass_code(CNT_W);

  logic [SEL_W-1:0] sel_q;
  logic             dec_pass;
  logic [CNT_W-1:0] dec_tap;
  logic             pass_q, pass_d;
  logic [CNT_W-1:0] tap_q, tap_d;

  // Select register on the rising edge; resets to the stop code.
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) sel_q <= '0;
    else             sel_q <= sel_i;
  end

  // Decode: code c in 1..CNT_W enables tap CNT_W-c; everything else stops.
  always_comb begin
    dec_pass = (sel_q == SEL_W'(PASS_CODE));
    dec_tap  = '0;
    for (int c = 1; c <= int'(CNT_W); c++) begin
      if (sel_q == SEL_W'(c)) dec_tap[CNT_W-c] = 1'b1;
    end
  end

  // New enables load only while the counter reads zero (all taps low).
  always_comb begin
    pass_d = pass_q;
    tap_d  = tap_q;
    if (wrap_i) begin
      pass_d = dec_pass;
      tap_d  = dec_tap;
    end
  end

  // Falling-edge register: updates while the input clock is low.
  always_ff @(negedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pass_q <= 1'b0;
      tap_q  <= '0;
    end else begin
      pass_q <= pass_d;
      tap_q  <= tap_d;
    end
  end

  assign pass_o = pass_q;
  assign tap_o  = tap_q;
endmodule

// File: rtl/clkdiv_pow2.sv
module clkdiv_pow2 #(
  parameter int unsigned CNT_W = clkdiv_pkg::DEF_CNT_W,
  parameter int unsigned SEL_W = clkdiv_pkg::DEF_SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             clk_o
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;
  logic             pass_en;
  logic [CNT_W-1:0] tap_en;
  logic [CNT_W-1:0] tap_gated;
  logic             div_clk;

  clkdiv_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  clkdiv_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_sync_n (rst_sync_n),
    .cnt_en_i   (1'b1),
    .cnt_o      (cnt),
    .zero_o     (cnt_zero)
  );

  clkdiv_sel_apply #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_sel (
    .clk_i      (clk_i),
    .rst_sync_n (rst_sync_n),
    .sel_i      (div_sel_i),
    .wrap_i     (cnt_zero),
    .pass_o     (pass_en),
    .tap_o      (tap_en)
  );

  // One AND gate per counter tap; at most one enable is set.
  for (genvar k = 0; k < int'(CNT_W); k++) begin : g_tap
    assign tap_gated[k] = tap_en[k] & cnt[k];
  end

  assign div_clk = |tap_gated;
  assign clk_o   = (pass_en & clk_i) | div_clk;

  // R6: enables may only change in a cycle where the counter read zero
  p_apply_at_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!$stable(tap_en) || !$stable(pass_en)) |-> cnt_zero);

  // R2: with no source enabled the output clock is low
  p_off_low_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ((tap_en == '0) && !pass_en) |-> !clk_o);

  // R7: at the wrap point every source is low, so switching is clean
  p_wrap_low_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    cnt_zero |-> !clk_o);

  // R3: never more than one clock source enabled
  p_single_source_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $onehot0({pass_en, tap_en}));
endmodule

// File: tb/test_clkdiv_pow2.sv
module test_clkdiv_pow2;
  localparam int CLK_PERIOD = 20;
  localparam int QTR        = CLK_PERIOD / 4;

  logic       clk;
  logic       rst_n;
  logic [3:0] sel;
  logic       clk_o;

  int n_tests;
  int n_fail;

  int min_hi, max_hi, min_lo, max_lo, n_hi, n_lo, first_hi;
  bit any_high;

  clkdiv_pow2 i_clkdiv_pow2 (
    .clk_i     (clk),
    .rst_n     (rst_n),
    .div_sel_i (sel),
    .clk_o     (clk_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired before the run completed");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // Expected high (and low) phase length in half-cycles; 0 means stopped.
  function automatic int half_len(input int code);
    if (code >= 1 && code <= 6) return 2 ** (7 - code);
    if (code == 7) return 1;
    return 0;
  endfunction

  task automatic record_run(input logic v, input int len);
    if (v) begin
      n_hi++;
      if (len < min_hi) min_hi = len;
      if (len > max_hi) max_hi = len;
    end else begin
      n_lo++;
      if (len < min_lo) min_lo = len;
      if (len > max_lo) max_lo = len;
    end
  endtask

  // Samples clk_o once per half-cycle; complete runs only are recorded.
  task automatic run_window(input int halves, input int change_at, input logic [3:0] new_sel);
    logic cur;
    logic v;
    int   len;
    bit   started;
    min_hi = 1 << 30; max_hi = 0; min_lo = 1 << 30; max_lo = 0;
    n_hi = 0; n_lo = 0; any_high = 0; first_hi = -1;
    cur = 1'b0; len = 0; started = 0;
    for (int i = 0; i < halves; i++) begin
      if (i % 2 == 0) @(posedge clk); else @(negedge clk);
      #(QTR);
      v = clk_o;
      if (v) any_high = 1;
      if (v && change_at >= 0 && i >= change_at && first_hi < 0) first_hi = i - change_at;
      if (i == 0) begin
        cur = v; len = 1;
      end else if (v == cur) begin
        len++;
      end else begin
        if (started) record_run(cur, len);
        started = 1; cur = v; len = 1;
      end
      if (i == change_at) sel = new_sel;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_steady(input int code);
    int h;
    h = half_len(code);
    run_window(600, -1, 4'd0);
    if (h == 0) begin
      if (code >= 8) check(!any_high, "R5", $sformatf("reserved code %0d high seen", code), any_high, 0);
      else           check(!any_high, "R2", "stop code high seen", any_high, 0);
    end else if (code == 7) begin
      check(n_hi > 0 && min_hi == 1 && max_hi == 1 && min_lo == 1 && max_lo == 1,
            "R4", "pass-through phase length", max_hi, 1);
    end else begin
      check(n_hi > 0 && n_lo > 0 && min_hi == h && max_hi == h && min_lo == h && max_lo == h,
            "R3", $sformatf("code %0d phase length", code), max_hi, h);
    end
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    rst_n   = 1'b0;
    sel     = 4'd7;

    // R1: reset keeps output low even with pass-through on the select
    repeat (3) @(posedge clk);
    run_window(40, -1, 4'd7);
    check(!any_high, "R1", "output high during reset", any_high, 0);

    @(negedge clk);
    rst_n = 1'b1;
    // R1: after release with the select at 0 the output stays stopped
    sel = 4'd0;
    repeat (4) @(posedge clk);
    run_window(200, -1, 4'd0);
    check(!any_high, "R1", "output high after reset at stop code", any_high, 0);

    // R2 R3 R4 R5: every code held steady
    for (int c = 0; c < 16; c++) begin
      sel = 4'(c);
      repeat (80) @(posedge clk);
      check_steady(c);
    end

    // R6 R7: every ordered pair of distinct valid codes, switched while running
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        int ha, hb, hmin, hmax;
        if (a == b) continue;
        ha = half_len(a); hb = half_len(b);
        hmin = (ha == 0) ? hb : ((hb == 0) ? ha : ((ha < hb) ? ha : hb));
        hmax = (ha > hb) ? ha : hb;
        sel = 4'(a);
        repeat (80) @(posedge clk);
        run_window(600, 100, 4'(b));
        check((n_hi == 0 || (min_hi >= hmin && max_hi <= hmax)) &&
              (n_lo == 0 || min_lo >= hmin),
              "R7", $sformatf("switch %0d->%0d shortest phase", a, b),
              (n_hi == 0) ? min_lo : min_hi, hmin);
        if (a == 0) begin
          check(first_hi >= 0 && first_hi <= 132 + hb,
                "R6", $sformatf("switch 0->%0d first high delay", b), first_hi, 132 + hb);
        end else begin
          check_steady(b);
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule